// File: doc/BRIEF.md
# Maskable Protocol Interrupt Controller

This block produces the two host interrupt lines of a bus protocol controller. Bus condition detectors elsewhere in the controller hand it single-cycle event pulses. The pulses mark four things: a finished command, a lost arbitration, an attention condition and a bus reset. Each accepted event latches a cause bit in a sense register. A host clears a cause bit by writing 1 to that bit.

A control register holds three enables. One masks the bus-reset contribution to the general interrupt. One lets a lost arbitration count as a command-complete cause. One lets an attention condition raise a service-required cause, and only while the controller is acting as target.

Bus reset always drives a separate interrupt line that no mask can block. Software can tell a lost arbitration from a real completion by one flag. That flag shows a pending command-complete cause while neither role input is active.

Top module: `proto_irq_ctrl`

## Requirements
- R1: `irq_bus_rst` rises on the clock edge that samples `evt_bus_rst`. It stays high until sense bit 0 is cleared. No control bit affects it.
- R2: While control bit 4 is 0, a pending bus-reset cause (sense bit 0) drives `irq_gen` high. While control bit 4 is 1, that cause does not contribute to `irq_gen`.
- R3: `evt_cmd_done` sets sense bit 4 (command complete) on the edge that samples it. Sense bit 4 always drives `irq_gen`.
- R4: `evt_arb_lost` sets sense bit 4 only while control bit 6 is 1. Otherwise it has no effect.
- R5: `cc_lost_arb` is high exactly when sense bit 4 is set and both `role_target` and `role_initiator` are low.
- R6: `evt_attn` sets sense bit 3 (service required) only when control bit 5 is 1 and `role_target` is 1 in the same cycle.
- R7: Sense bit 3 clears on a write with data bit 3 set. It also clears on the first edge that samples `role_target` low.
- R8: A sense write clears every bit written as 1 and leaves every bit written as 0 unchanged. Sense bits 1, 2, 5, 6 and 7 always read 0.
- R9: When an event and a clear of the same sense bit fall on the same edge, the event wins and the bit stays set.
- R10: `irq_gen` stays high while any enabled cause is pending. It falls only when the last one is cleared.
- R11: After reset, the control and sense registers read 0 and both interrupts are low. A control write takes all 8 bits, which read back from `ctl_q` after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_cmd_done | input | 1 | Command completion pulse |
| evt_arb_lost | input | 1 | Lost arbitration pulse |
| evt_attn | input | 1 | Attention condition pulse |
| evt_bus_rst | input | 1 | Bus reset detection pulse |
| role_target | input | 1 | Controller is acting as target |
| role_initiator | input | 1 | Controller is acting as initiator |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| sense_wr | input | 1 | Sense register write-one-to-clear strobe |
| sense_wdata | input | 8 | Sense register clear mask |
| ctl_q | output | 8 | Control register contents |
| sense_q | output | 8 | Pending causes |
| irq_bus_rst | output | 1 | Non-maskable bus reset interrupt |
| irq_gen | output | 1 | Maskable general interrupt |
| cc_lost_arb | output | 1 | Command-complete cause came from lost arbitration |

## Verification
The sense register and the control register change on the rising edge that samples an event or a write. Both interrupt lines are decoded from those registers, so each result appears one edge after its stimulus. `cc_lost_arb` also follows the role inputs within the same cycle. The role-end clear of sense bit 3 takes one edge. The bench drives every input on the falling edge and lets one rising edge pass. It then compares all outputs on the next falling edge against a behavioural model that steps on the same rising edge.

// File: rtl/proto_irq_pkg.sv
package proto_irq_pkg;

  // Sense register bit positions
  localparam int SNS_BUS_RST = 0;
  localparam int SNS_SVC_REQ = 3;
  localparam int SNS_CMD_CMP = 4;

  // Control register bit positions
  localparam int CTL_RST_MASK = 4;
  localparam int CTL_ATTN_EN  = 5;
  localparam int CTL_ARB_EN   = 6;

  localparam int NUM_CAUSE = 3;

  typedef enum logic [1:0] {
    CAUSE_BUS_RST = 2'd0,
    CAUSE_SVC_REQ = 2'd1,
    CAUSE_CMD_CMP = 2'd2
  } cause_e;

  typedef struct packed {
    logic rst_mask;
    logic attn_en;
    logic arb_en;
  } ctl_fields_t;

  typedef struct packed {
    logic cmd_done;
    logic arb_lost;
    logic attn;
    logic bus_rst;
  } evt_t;

  function automatic int cause_pos(int idx);
    case (idx)
      0:       return SNS_BUS_RST;
      1:       return SNS_SVC_REQ;
      default: return SNS_CMD_CMP;
    endcase
  endfunction

endpackage

// File: rtl/pic_ctl_reg.sv
module pic_ctl_reg
  import proto_irq_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] q_o,
  output ctl_fields_t      fields_o
);

  logic [REG_W-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else if (wr_i) q_r <= wdata_i;
  end

  assign q_o = q_r;

  always_comb begin
    fields_o.rst_mask = q_r[CTL_RST_MASK];
    fields_o.attn_en  = q_r[CTL_ATTN_EN];
    fields_o.arb_en   = q_r[CTL_ARB_EN];
  end

  AST_CTL_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (q_o == $past(wdata_i))); // R11

endmodule

// File: rtl/pic_w1c_cell.sv
module pic_w1c_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  logic q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_r <= 1'b0;
    else if (set_i) q_r <= 1'b1;
    else if (clr_i) q_r <= 1'b0;
  end

  assign q_o = q_r;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o); // R9

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> (q_o == $past(q_o))); // R8

endmodule

// File: rtl/pic_sense_bank.sv
module pic_sense_bank
  import proto_irq_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  evt_t             evt_i,
  input  ctl_fields_t      ctl_i,
  input  logic             role_target_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] sense_o
);

  logic [NUM_CAUSE-1:0] set_v;
  logic [NUM_CAUSE-1:0] clr_v;
  logic [NUM_CAUSE-1:0] q_v;

  always_comb begin
    set_v[CAUSE_BUS_RST] = evt_i.bus_rst;
    set_v[CAUSE_SVC_REQ] = evt_i.attn & ctl_i.attn_en & role_target_i;
    set_v[CAUSE_CMD_CMP] = evt_i.cmd_done | (evt_i.arb_lost & ctl_i.arb_en);
  end

  generate
    for (genvar gi = 0; gi < NUM_CAUSE; gi++) begin : g_cause
      localparam int POS = cause_pos(gi);
      if (gi == int'(CAUSE_SVC_REQ)) begin : g_role_clr
        assign clr_v[gi] = (wr_i & wdata_i[POS]) | ~role_target_i;
      end else begin : g_plain_clr
        assign clr_v[gi] = wr_i & wdata_i[POS];
      end
      pic_w1c_cell u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_v[gi]),
        .clr_i (clr_v[gi]),
        .q_o   (q_v[gi])
      );
    end
  endgenerate

  always_comb begin
    sense_o = '0;
    for (int i = 0; i < NUM_CAUSE; i++) sense_o[cause_pos(i)] = q_v[i];
  end

  AST_ATTN_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i.attn && !ctl_i.attn_en && !sense_o[SNS_SVC_REQ]) |=> !sense_o[SNS_SVC_REQ]); // R6

  AST_ARB_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i.arb_lost && !ctl_i.arb_en && !evt_i.cmd_done && !sense_o[SNS_CMD_CMP])
      |=> !sense_o[SNS_CMD_CMP]); // R4

endmodule

// File: rtl/pic_irq_out.sv
module pic_irq_out
  import proto_irq_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic [REG_W-1:0] sense_i,
  input  ctl_fields_t      ctl_i,
  input  logic             role_target_i,
  input  logic             role_initiator_i,
  output logic             irq_bus_rst_o,
  output logic             irq_gen_o,
  output logic             cc_lost_arb_o
);

  logic rst_part;

  always_comb begin
    irq_bus_rst_o = sense_i[SNS_BUS_RST];
    rst_part      = sense_i[SNS_BUS_RST] & ~ctl_i.rst_mask;
    irq_gen_o     = rst_part | sense_i[SNS_SVC_REQ] | sense_i[SNS_CMD_CMP];
    cc_lost_arb_o = sense_i[SNS_CMD_CMP] & ~role_target_i & ~role_initiator_i;
  end

endmodule

// File: rtl/proto_irq_ctrl.sv
module proto_irq_ctrl
  import proto_irq_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_cmd_done,
  input  logic             evt_arb_lost,
  input  logic             evt_attn,
  input  logic             evt_bus_rst,
  input  logic             role_target,
  input  logic             role_initiator,
  input  logic             ctl_wr,
  input  logic [REG_W-1:0] ctl_wdata,
  input  logic             sense_wr,
  input  logic [REG_W-1:0] sense_wdata,
  output logic [REG_W-1:0] ctl_q,
  output logic [REG_W-1:0] sense_q,
  output logic             irq_bus_rst,
  output logic             irq_gen,
  output logic             cc_lost_arb
);

  ctl_fields_t ctl_f;
  evt_t        evt;

  always_comb begin
    evt.cmd_done = evt_cmd_done;
    evt.arb_lost = evt_arb_lost;
    evt.attn     = evt_attn;
    evt.bus_rst  = evt_bus_rst;
  end

  pic_ctl_reg #(.REG_W(REG_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (ctl_wr),
    .wdata_i  (ctl_wdata),
    .q_o      (ctl_q),
    .fields_o (ctl_f)
  );

  pic_sense_bank #(.REG_W(REG_W)) u_sense (
    .clk           (clk),
    .rst_n         (rst_n),
    .evt_i         (evt),
    .ctl_i         (ctl_f),
    .role_target_i (role_target),
    .wr_i          (sense_wr),
    .wdata_i       (sense_wdata),
    .sense_o       (sense_q)
  );

  pic_irq_out #(.REG_W(REG_W)) u_out (
    .sense_i          (sense_q),
    .ctl_i            (ctl_f),
    .role_target_i    (role_target),
    .role_initiator_i (role_initiator),
    .irq_bus_rst_o    (irq_bus_rst),
    .irq_gen_o        (irq_gen),
    .cc_lost_arb_o    (cc_lost_arb)
  );

  AST_BUS_RST_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_bus_rst |=> irq_bus_rst); // R1

  AST_BUS_RST_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_bus_rst && !ctl_q[CTL_RST_MASK] && !ctl_wr) |=> irq_gen); // R2

  AST_CMD_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cmd_done |=> irq_gen); // R3

  AST_ROLE_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !role_target |=> !sense_q[SNS_SVC_REQ]); // R7

  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_gen && !sense_wr && !ctl_wr && role_target) |=> irq_gen); // R10

endmodule

// File: tb/proto_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module proto_irq_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_cmd_done = 0, evt_arb_lost = 0, evt_attn = 0, evt_bus_rst = 0;
  logic role_target = 0, role_initiator = 0;
  logic ctl_wr = 0, sense_wr = 0;
  logic [7:0] ctl_wdata = '0, sense_wdata = '0;
  logic [7:0] ctl_q, sense_q;
  logic irq_bus_rst, irq_gen, cc_lost_arb;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  proto_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .evt_cmd_done(evt_cmd_done), .evt_arb_lost(evt_arb_lost),
    .evt_attn(evt_attn), .evt_bus_rst(evt_bus_rst),
    .role_target(role_target), .role_initiator(role_initiator),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .sense_wr(sense_wr), .sense_wdata(sense_wdata),
    .ctl_q(ctl_q), .sense_q(sense_q),
    .irq_bus_rst(irq_bus_rst), .irq_gen(irq_gen), .cc_lost_arb(cc_lost_arb)
  );

  // Behavioural reference model
  bit m_rst, m_svc, m_cmd;
  bit [7:0] m_ctl;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rst = 0; m_svc = 0; m_cmd = 0; m_ctl = 0;
    end else begin
      if (evt_bus_rst) m_rst = 1;
      else if (sense_wr && sense_wdata[0]) m_rst = 0;
      if (evt_attn && m_ctl[5] && role_target) m_svc = 1;
      else if ((sense_wr && sense_wdata[3]) || !role_target) m_svc = 0;
      if (evt_cmd_done || (evt_arb_lost && m_ctl[6])) m_cmd = 1;
      else if (sense_wr && sense_wdata[4]) m_cmd = 0;
      if (ctl_wr) m_ctl = ctl_wdata;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit [7:0] e_sense;
      bit e_gen, e_cc;
      e_sense = {3'b0, m_cmd, m_svc, 3'b0} | {7'b0, m_rst};
      e_gen = (m_rst && !m_ctl[4]) || m_svc || m_cmd;
      e_cc = m_cmd && !role_target && !role_initiator;
      check(irq_bus_rst == m_rst, "R1 model irq_bus_rst", irq_bus_rst, m_rst);
      check(irq_gen == e_gen, "R10 model irq_gen", irq_gen, e_gen);
      check(sense_q == e_sense, "R8 model sense_q", sense_q, e_sense);
      check(cc_lost_arb == e_cc, "R5 model cc_lost_arb", cc_lost_arb, e_cc);
      check(ctl_q == m_ctl, "R11 model ctl_q", ctl_q, m_ctl);
    end
  end

  task automatic cyc();
    @(posedge clk); @(negedge clk);
    evt_cmd_done = 0; evt_arb_lost = 0; evt_attn = 0; evt_bus_rst = 0;
    ctl_wr = 0; sense_wr = 0;
  endtask

  task automatic wctl(input logic [7:0] v);
    ctl_wr = 1; ctl_wdata = v; cyc();
  endtask

  task automatic wsense(input logic [7:0] v);
    sense_wr = 1; sense_wdata = v; cyc();
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ctl_q == 0 && sense_q == 0, "R11 reset regs", {ctl_q, sense_q}, 0);
    check(!irq_gen && !irq_bus_rst, "R11 reset irqs", {irq_gen, irq_bus_rst}, 0);
    rst_n = 1;
    cyc();

    wctl(8'hA5);
    check(ctl_q == 8'hA5, "R11 ctl readback", ctl_q, 8'hA5);
    wctl(8'h00);

    evt_bus_rst = 1; cyc();
    check(irq_bus_rst == 1, "R1 bus reset line", irq_bus_rst, 1);
    check(irq_gen == 1, "R2 unmasked reset", irq_gen, 1);
    wctl(8'h10);
    check(irq_gen == 0, "R2 masked reset", irq_gen, 0);
    check(irq_bus_rst == 1, "R1 mask ignored", irq_bus_rst, 1);
    wsense(8'h00);
    check(sense_q == 8'h01, "R8 zero write keeps", sense_q, 8'h01);
    wsense(8'hEE);
    check(sense_q == 8'h01, "R8 other bits keep", sense_q, 8'h01);
    wsense(8'h01);
    check(sense_q == 0 && !irq_bus_rst, "R1 cleared", sense_q, 0);

    evt_cmd_done = 1; cyc();
    check(sense_q == 8'h10 && irq_gen, "R3 command done", sense_q, 8'h10);
    check(cc_lost_arb == 1, "R5 no role", cc_lost_arb, 1);
    role_initiator = 1; #1;
    check(cc_lost_arb == 0, "R5 initiator role", cc_lost_arb, 0);
    role_initiator = 0;
    wsense(8'h10);

    evt_arb_lost = 1; cyc();
    check(sense_q == 0 && !irq_gen, "R4 arb disabled", sense_q, 0);
    wctl(8'h40);
    evt_arb_lost = 1; cyc();
    check(sense_q == 8'h10, "R4 arb enabled", sense_q, 8'h10);
    wsense(8'h10);

    role_target = 1;
    evt_attn = 1; cyc();
    check(sense_q == 0, "R6 attn disabled", sense_q, 0);
    wctl(8'h20);
    role_target = 0;
    evt_attn = 1; cyc();
    check(sense_q == 0, "R6 attn not target", sense_q, 0);
    role_target = 1;
    evt_attn = 1; cyc();
    check(sense_q == 8'h08 && irq_gen, "R6 attn as target", sense_q, 8'h08);
    role_target = 0; cyc();
    check(sense_q == 0, "R7 role end clears", sense_q, 0);
    role_target = 1;
    evt_attn = 1; cyc();
    wsense(8'h08);
    check(sense_q == 0, "R7 write clears", sense_q, 0);

    evt_cmd_done = 1; sense_wr = 1; sense_wdata = 8'h10; cyc();
    check(sense_q == 8'h10, "R9 set beats clear", sense_q, 8'h10);

    evt_attn = 1; cyc();
    check(sense_q == 8'h18, "R10 two causes", sense_q, 8'h18);
    wsense(8'h10);
    check(irq_gen == 1, "R10 one left", irq_gen, 1);
    wsense(8'h08);
    check(irq_gen == 0, "R10 all cleared", irq_gen, 0);
    role_target = 0;
    cyc();

    finish_run();
  end

endmodule